// File: doc/BRIEF.md
# Prioritized Limit Alert Controller

This block watches three measurement words (a signed shunt reading, an unsigned bus reading and an unsigned power reading). Each time the measurement path signals that a conversion has finished, it compares one of them with a programmable 16-bit threshold. A control register holds five threshold-function enables. At most one of them is ever active, so the controller resolves conflicting writes with a fixed priority. A sixth enable sends the conversion-ready flag to the same alert output. Latch or transparent behaviour and the pin polarity can both be selected.

Software programs the control word and the threshold through a simple register write port. It reads the control/status word back combinationally. A read strobe marks the read, and that strobe clears flags according to the selected mode. A separate strobe stands for a configuration write that is not a power-down selection.

The block carries no data stream. Every input is a register strobe or a sampled measurement level, so no valid/ready handshake applies and nothing is back-pressured. A conversion strobe is consumed in the cycle it is high.

Top module: `limit_alert_ctrl`

## Requirements
- R1: The control/status word reads back the shunt-over enable in bit 15, shunt-under in 14, bus-over in 13, bus-under in 12, power-over in 11, ready-routing in 10, the alert flag in 4, the ready flag in 3, polarity in 1 and latch mode in 0. Bits 9:5 and 2 read 0, and writes to bits 9:2 have no effect on the readback.
- R2: When a control write sets several threshold enables, only the highest one in the order bit 15 > 14 > 13 > 12 > 11 is kept, and the lower ones are cleared.
- R3: On a conversion strobe, the shunt-over function trips when the shunt word is strictly greater than the threshold, and the shunt-under function trips when it is strictly less. Both comparisons are two's complement.
- R4: On a conversion strobe, the bus-over function trips when the bus word is strictly greater than the threshold, and bus-under trips when it is strictly less. Power-over trips when the power word is strictly greater. All three comparisons are unsigned, and equal values do not trip.
- R5: In latch mode (bit 0 = 1), once the alert flag sets it stays set through later clean conversions. The next control/status read clears it, and the read itself still returns it as 1.
- R6: In transparent mode (bit 0 = 0), a conversion that does not trip the enabled function clears the alert flag.
- R7: Every conversion strobe sets the ready flag. A control/status read clears it, and so does a non-power-down configuration strobe. A conversion strobe in the same cycle wins.
- R8: With ready-routing enabled (bit 10), a set ready flag asserts the alert, just as a set alert flag does.
- R9: With polarity 0 the alert pin is low when active and high when idle. With polarity 1 it is high when active.
- R10: After reset, the readback word and the threshold are zero and the alert pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shunt_val | input | 16 | Shunt result, two's complement |
| bus_val | input | 16 | Bus result, unsigned |
| pwr_val | input | 16 | Power result, unsigned |
| conv_done | input | 1 | One-cycle conversion-complete strobe |
| cfg_wr_clr | input | 1 | Non-power-down configuration write strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the threshold |
| reg_wdata | input | 16 | Write data |
| mask_rd | input | 1 | Control/status read strobe |
| mask_rdata | output | 16 | Control/status readback |
| alert_pin | output | 1 | Alert output level |

## Verification
A flag register that fails to clear, or that clears too early, shows up on the alert pin and in bit 4 or bit 3 of the readback one clock after the conversion or read strobe. A faulty priority resolver leaves more than one enable visible in the readback right after the write. It can also trip on the wrong comparison at the next conversion. A sign error in the shunt comparison flips the alert for negative readings against a positive threshold on the first such conversion.

// File: rtl/lac_pkg.sv
package lac_pkg;
  localparam int DW   = 16;
  localparam int NFN  = 5;
  // bit positions of the control/status word
  localparam int B_EN_LO = 11;
  localparam int B_CNVR  = 10;
  localparam int B_AFF   = 4;
  localparam int B_CVRF  = 3;
  localparam int B_APOL  = 1;
  localparam int B_LEN   = 0;

  typedef struct packed {
    logic [NFN-1:0] en;   // [4]=shunt over .. [0]=power over
    logic           cnvr;
    logic           apol;
    logic           len;
  } lac_ctrl_t;
endpackage

// File: rtl/lac_prio.sv
module lac_prio #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lac_cmp.sv
module lac_cmp #(
  parameter int W = 16,
  parameter int N = 5
) (
  input  logic [W-1:0] shunt_val,
  input  logic [W-1:0] bus_val,
  input  logic [W-1:0] pwr_val,
  input  logic [W-1:0] limit,
  input  logic [N-1:0] en,
  output logic         hit
);
  logic [N-1:0] trip;

  always_comb begin
    trip    = '0;
    trip[4] = $signed(shunt_val) > $signed(limit);
    trip[3] = $signed(shunt_val) < $signed(limit);
    trip[2] = bus_val > limit;
    trip[1] = bus_val < limit;
    trip[0] = pwr_val > limit;
  end

  assign hit = |(trip & en);
endmodule

// File: rtl/lac_flags.sv
module lac_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_done,
  input  logic hit,
  input  logic mask_rd,
  input  logic cfg_wr_clr,
  input  logic len,
  output logic aff,
  output logic cvrf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aff  <= 1'b0;
      cvrf <= 1'b0;
    end else begin
      if (conv_done) begin
        cvrf <= 1'b1;
      end else if (mask_rd || cfg_wr_clr) begin
        cvrf <= 1'b0;
      end

      if (conv_done && hit) begin
        aff <= 1'b1;
      end else if (conv_done && !len) begin
        aff <= 1'b0;
      end else if (mask_rd && len) begin
        aff <= 1'b0;
      end
    end
  end

  // R7
  cvrf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> cvrf);
  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aff && len && !mask_rd) |=> aff);
  // R6
  transp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !hit && !len) |=> !aff);
  // R3
  trip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && hit) |=> aff);
endmodule

// File: rtl/limit_alert_ctrl.sv
module limit_alert_ctrl
  import lac_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] shunt_val,
  input  logic [W-1:0] bus_val,
  input  logic [W-1:0] pwr_val,
  input  logic         conv_done,
  input  logic         cfg_wr_clr,
  input  logic         reg_wr,
  input  logic         reg_sel,
  input  logic [W-1:0] reg_wdata,
  input  logic         mask_rd,
  output logic [W-1:0] mask_rdata,
  output logic         alert_pin
);
  localparam int EN_HI = B_EN_LO + NFN - 1;

  lac_ctrl_t    ctrl_q;
  logic [W-1:0] lim_q;
  logic [NFN-1:0] en_grant;
  logic         hit;
  logic         aff;
  logic         cvrf;
  logic         active;

  lac_prio #(.N(NFN)) u_prio (
    .req   (reg_wdata[EN_HI:B_EN_LO]),
    .grant (en_grant)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lim_q  <= '0;
    end else if (reg_wr) begin
      if (!reg_sel) begin
        ctrl_q.en   <= en_grant;
        ctrl_q.cnvr <= reg_wdata[B_CNVR];
        ctrl_q.apol <= reg_wdata[B_APOL];
        ctrl_q.len  <= reg_wdata[B_LEN];
      end else begin
        lim_q <= reg_wdata;
      end
    end
  end

  lac_cmp #(.W(W), .N(NFN)) u_cmp (
    .shunt_val (shunt_val),
    .bus_val   (bus_val),
    .pwr_val   (pwr_val),
    .limit     (lim_q),
    .en        (ctrl_q.en),
    .hit       (hit)
  );

  lac_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_done  (conv_done),
    .hit        (hit),
    .mask_rd    (mask_rd),
    .cfg_wr_clr (cfg_wr_clr),
    .len        (ctrl_q.len),
    .aff        (aff),
    .cvrf       (cvrf)
  );

  always_comb begin
    mask_rdata                 = '0;
    mask_rdata[EN_HI:B_EN_LO]  = ctrl_q.en;
    mask_rdata[B_CNVR]         = ctrl_q.cnvr;
    mask_rdata[B_AFF]          = aff;
    mask_rdata[B_CVRF]         = cvrf;
    mask_rdata[B_APOL]         = ctrl_q.apol;
    mask_rdata[B_LEN]          = ctrl_q.len;
  end

  assign active    = aff | (ctrl_q.cnvr & cvrf);
  assign alert_pin = ctrl_q.apol ? active : ~active;

  // R2
  one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_rdata[EN_HI:B_EN_LO]));
  // R9
  aff_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aff |-> (alert_pin == ctrl_q.apol));
  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rdata[9:5] == 5'd0) && !mask_rdata[2]);
endmodule

// File: tb/sim_limit_alert_ctrl.sv
module sim_limit_alert_ctrl;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] shunt_val = '0, bus_val = '0, pwr_val = '0;
  logic        conv_done = 1'b0, cfg_wr_clr = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0, mask_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] mask_rdata;
  logic        alert_pin;

  int total = 0;
  int bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  limit_alert_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .shunt_val(shunt_val), .bus_val(bus_val),
    .pwr_val(pwr_val), .conv_done(conv_done), .cfg_wr_clr(cfg_wr_clr),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mask_rd(mask_rd), .mask_rdata(mask_rdata), .alert_pin(alert_pin)
  );

  // {control, threshold, shunt, bus, power, expected alert flag}
  localparam int NV = 12;
  localparam logic [80:0] VEC [NV] = '{
    {16'h8000, 16'h0010, 16'h0020, 16'h0000, 16'h0000, 1'b1}, // R3 over
    {16'h8000, 16'h0010, 16'hFFF0, 16'h0000, 16'h0000, 1'b0}, // R3 signed, R6 clear
    {16'h4000, 16'h0000, 16'hFFF0, 16'h0000, 16'h0000, 1'b1}, // R3 under
    {16'h4000, 16'h0000, 16'h0010, 16'h0000, 16'h0000, 1'b0}, // R3
    {16'h2000, 16'h8000, 16'h0000, 16'h9000, 16'h0000, 1'b1}, // R4 unsigned
    {16'h2000, 16'h8000, 16'h0000, 16'h7000, 16'h0000, 1'b0}, // R4
    {16'h1000, 16'h1000, 16'h0000, 16'h0800, 16'h0000, 1'b1}, // R4 bus under
    {16'h0800, 16'h0100, 16'h0000, 16'h0000, 16'h0200, 1'b1}, // R4 power
    {16'h0800, 16'h0100, 16'h0000, 16'h0000, 16'h0100, 1'b0}, // R4 equal
    {16'hC000, 16'h0010, 16'hFFF0, 16'h0000, 16'h0000, 1'b0}, // R2 over wins
    {16'hF800, 16'h0000, 16'h0001, 16'h0000, 16'h0000, 1'b1}, // R2
    {16'h0000, 16'h0000, 16'h7FFF, 16'hFFFF, 16'hFFFF, 1'b0}  // none enabled
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic conv(input logic [15:0] s, input logic [15:0] b, input logic [15:0] p);
    @(negedge clk);
    shunt_val = s; bus_val = b; pwr_val = p; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic rd(output logic [15:0] d);
    @(negedge clk);
    mask_rd = 1'b1;
    #1 d = mask_rdata;
    @(negedge clk);
    mask_rd = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    // R10
    chk("R10 readback", mask_rdata, 16'h0000);
    chk("R10 pin", {15'd0, alert_pin}, 16'h0001);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      wr(1'b0, VEC[i][80:65]);
      wr(1'b1, VEC[i][64:49]);
      conv(VEC[i][48:33], VEC[i][32:17], VEC[i][16:1]);
      chk("R3/R4/R6 flag", {15'd0, mask_rdata[4]}, {15'd0, VEC[i][0]});
      chk("R9 pin", {15'd0, alert_pin}, {15'd0, ~VEC[i][0]});
      if (i == 9)
        chk("R2 enables", mask_rdata & 16'hFC00, 16'h8000);
      if (i == 10)
        chk("R2 enables", mask_rdata & 16'hFC00, 16'h8000);
    end
    chk("R7 ready set", {15'd0, mask_rdata[3]}, 16'h0001);
    rd(d);
    chk("R7 read clears", {15'd0, mask_rdata[3]}, 16'h0000);

    // latch mode
    wr(1'b0, 16'h8001);
    wr(1'b1, 16'h0010);
    conv(16'h0020, 16'h0, 16'h0);
    conv(16'h0000, 16'h0, 16'h0);
    chk("R5 held", {15'd0, mask_rdata[4]}, 16'h0001);
    chk("R5 pin held", {15'd0, alert_pin}, 16'h0000);
    rd(d);
    chk("R5 read returns flag", {15'd0, d[4]}, 16'h0001);
    chk("R5 cleared", {15'd0, mask_rdata[4]}, 16'h0000);
    chk("R5 pin idle", {15'd0, alert_pin}, 16'h0001);

    // ready routing
    wr(1'b0, 16'h0400);
    conv(16'h0, 16'h0, 16'h0);
    chk("R8 pin active", {15'd0, alert_pin}, 16'h0000);
    rd(d);
    chk("R8 pin idle after read", {15'd0, alert_pin}, 16'h0001);
    conv(16'h0, 16'h0, 16'h0);
    @(negedge clk);
    cfg_wr_clr = 1'b1;
    @(negedge clk);
    cfg_wr_clr = 1'b0;
    chk("R7 config clears", {15'd0, mask_rdata[3]}, 16'h0000);

    // polarity
    wr(1'b0, 16'h8002);
    conv(16'h0020, 16'h0, 16'h0);
    chk("R9 active high", {15'd0, alert_pin}, 16'h0001);
    conv(16'h0000, 16'h0, 16'h0);
    chk("R9 idle low", {15'd0, alert_pin}, 16'h0000);

    // read-only bits
    rd(d);
    wr(1'b0, 16'h03FC);
    chk("R1 readonly", mask_rdata, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule